// File: doc/BRIEF.md
# Serial Flash Command Engine

This peripheral lets a host run arbitrary commands on a serial configuration flash through a small byte-wide register window. The host loads a 16-bit serial clock count, an opcode byte and three address bytes, optionally fills an outgoing data window, and then writes a start key. The engine drops chip select, shifts out the opcode, the address and the outgoing data as one continuous bit stream for exactly the programmed number of serial clocks, and collects the bits returned by the flash into an incoming data window.

Every register and every data byte sits on an 8-byte stride. The host hands over bytes already bit-reversed, so the engine sends each byte least significant bit first and stores returned bytes the same way. A busy flag stays set from the start key until the last serial clock has finished. The host polls it and then reads the captured bytes, including a status byte it can poll for the flash's write-in-progress bit.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the busy byte at offset 0x01 reads 0, and every captured byte, including the one at offset 0x20, reads 0.
- R2: A bus write of 0xFF to offset 0x7F8 starts a cycle when the clock count (high byte at 0x00, low byte at 0x08) is nonzero. Any other value written there, or a clock count of zero, starts nothing.
- R3: During a cycle, chip select stays low for exactly N serial clocks, where N is the clock count. Each serial clock lasts CLK_DIV system clocks, and offset 0x01 reads 1 for exactly N*CLK_DIV system clocks, counted from the edge that takes the start write.
- R4: The outgoing stream is the opcode (0x10), then the address bytes at 0x18, 0x20 and 0x28, then write-window byte k taken from offset 0x30+8k. Each byte goes out least significant bit first, so stream bit i is bit i mod 8 of byte i/8.
- R5: The data output changes only while the serial clock is low, on its falling edge. The data input is sampled on the rising edge.
- R6: The capture header H is 32 clocks for opcodes 0xC0 and 0x40 and 8 clocks for every other opcode. The bit sampled on serial clock H+8j+b, counting from 0, is stored in bit b of captured byte j, which is read at offset 0x38+8j. Bits sampled before clock H are dropped.
- R7: A read of offset 0x20 returns captured byte 0. The status command uses this byte.
- R8: A start write, or a rewrite of the clock count, made while busy leaves the running cycle's length and clock count unchanged and does not start a second cycle.
- R9: Write-window bytes at index 128 and above send zeros. The capture window ends at index 246 (offset 0x7E8), so bits beyond it are dropped, and a read at 0x7F0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong bit counter or a wrong divider phase shows up within one command, either as a serial clock count that differs from N or as a busy period that is not N*CLK_DIV cycles. The bench measures both exactly on every command. A wrong stream index or a wrong header length moves bits between bytes. The bench logs every transmitted bit and compares every captured byte against a known flash pattern, so such a slip is caught on the first affected bit. The bench also checks the window edges (write byte 128, capture byte 246) and starts that are made while busy or with a wrong key.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int ADDR_W = 11;

    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 11'h000;
    localparam logic [ADDR_W-1:0] OFS_BUSY   = 11'h001;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 11'h008;
    localparam logic [ADDR_W-1:0] OFS_OPC    = 11'h010;
    localparam logic [ADDR_W-1:0] OFS_ADR_H  = 11'h018;
    localparam logic [ADDR_W-1:0] OFS_ADR_M  = 11'h020;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 11'h020;
    localparam logic [ADDR_W-1:0] OFS_ADR_L  = 11'h028;
    localparam logic [ADDR_W-1:0] OFS_TXWIN  = 11'h030;
    localparam logic [ADDR_W-1:0] OFS_RXWIN  = 11'h038;
    localparam logic [ADDR_W-1:0] OFS_GO     = 11'h7F8;

    localparam logic [7:0] GO_KEY     = 8'hFF;
    localparam logic [7:0] OPC_RDDATA = 8'hC0;
    localparam logic [7:0] OPC_PGWR   = 8'h40;

    typedef struct packed {
        logic [15:0] clocks;
        logic [7:0]  opcode;
        logic [7:0]  adr_h;
        logic [7:0]  adr_m;
        logic [7:0]  adr_l;
    } sfe_cfg_t;

    typedef enum logic {SQ_IDLE, SQ_RUN} sfe_state_t;

    function automatic logic [15:0] hdr_clocks(input logic [7:0] opc);
        return (opc == OPC_RDDATA || opc == OPC_PGWR) ? 16'd32 : 16'd8;
    endfunction

    function automatic logic [31:0] hdr_word(input sfe_cfg_t c);
        return {c.adr_l, c.adr_m, c.adr_h, c.opcode};
    endfunction

endpackage

// File: rtl/sfe_seq.sv
module sfe_seq
    import sfe_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [15:0] clocks,
    output logic        busy,
    output logic        sck,
    output logic        cs_n,
    output logic [15:0] bit_idx,
    output logic        cap_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

    sfe_state_t    state;
    logic [DW-1:0] div_cnt;
    logic [15:0]   total_q;
    logic          half_tick;

    assign half_tick = (state == SQ_RUN) && (div_cnt == DIV_LAST);
    assign cap_stb   = half_tick && !sck;
    assign busy      = (state == SQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            div_cnt <= '0;
            total_q <= '0;
            bit_idx <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go && clocks != 16'd0) begin
                        state   <= SQ_RUN;
                        total_q <= clocks;
                        div_cnt <= '0;
                        bit_idx <= '0;
                        sck     <= 1'b0;
                        cs_n    <= 1'b0;
                    end
                end
                default: begin
                    if (half_tick) begin
                        div_cnt <= '0;
                        if (!sck) begin
                            sck <= 1'b1;
                        end else begin
                            sck <= 1'b0;
                            if (bit_idx == 16'(total_q - 16'd1)) begin
                                state   <= SQ_IDLE;
                                cs_n    <= 1'b1;
                                bit_idx <= '0;
                            end else begin
                                bit_idx <= bit_idx + 16'd1;
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + DW'(1);
                    end
                end
            endcase
        end
    end

    AST_SCK_GATED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck) else $error("sck toggles with cs_n high"); // R3
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx < total_q)) else $error("bit index past count"); // R3
    AST_START_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (bit_idx == 16'd0 && !sck && !cs_n)) else $error("unclean start"); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || bit_idx == $past(bit_idx) || bit_idx == $past(bit_idx) + 16'd1))
        else $error("bit index jump"); // R3
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(total_q))) else $error("count changed while busy"); // R8

endmodule

// File: rtl/sfe_regs.sv
module sfe_regs
    import sfe_pkg::*;
#(
    parameter int TX_BYTES = 128,
    parameter int RX_BYTES = 247
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              busy,
    input  logic              cap_stb,
    input  logic              cap_bit,
    input  logic [15:0]       bit_idx,
    output sfe_cfg_t          cfg,
    output logic              go,
    output logic              tx_bit
);
    localparam int TX_IW = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1;
    localparam int RX_IW = (RX_BYTES > 1) ? $clog2(RX_BYTES) : 1;
    localparam logic [7:0]  TX_LIM8  = 8'(TX_BYTES);
    localparam logic [7:0]  RX_LIM8  = 8'(RX_BYTES);
    localparam logic [12:0] TX_LIM13 = 13'(TX_BYTES);
    localparam logic [12:0] RX_LIM13 = 13'(RX_BYTES);

    logic [7:0] tx_mem [TX_BYTES];
    logic [7:0] rx_mem [RX_BYTES];

    // Bus window decode
    logic [ADDR_W-1:0] tx_ofs, rx_ofs;
    logic [7:0]        tx_slot, rx_slot;
    logic              tx_hit, rx_hit;

    assign tx_ofs  = bus_addr - OFS_TXWIN;
    assign rx_ofs  = bus_addr - OFS_RXWIN;
    assign tx_slot = tx_ofs[ADDR_W-1:3];
    assign rx_slot = rx_ofs[ADDR_W-1:3];
    assign tx_hit  = (bus_addr[2:0] == 3'd0) && (bus_addr >= OFS_TXWIN) && (tx_slot < TX_LIM8);
    assign rx_hit  = (bus_addr[2:0] == 3'd0) && (bus_addr >= OFS_RXWIN) && (rx_slot < RX_LIM8);
    assign go      = bus_wr && (bus_addr == OFS_GO) && (bus_wdata == GO_KEY);

    // Capture position relative to the header
    logic [15:0] hdr, cap_rel;
    logic        cap_ok;

    assign hdr     = hdr_clocks(cfg.opcode);
    assign cap_rel = bit_idx - hdr;
    assign cap_ok  = cap_stb && (bit_idx >= hdr) && (cap_rel[15:3] < RX_LIM13);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            for (int i = 0; i < TX_BYTES; i++) tx_mem[i] <= 8'h00;
            for (int i = 0; i < RX_BYTES; i++) rx_mem[i] <= 8'h00;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    OFS_CNT_HI: cfg.clocks[15:8] <= bus_wdata;
                    OFS_CNT_LO: cfg.clocks[7:0]  <= bus_wdata;
                    OFS_OPC:    cfg.opcode       <= bus_wdata;
                    OFS_ADR_H:  cfg.adr_h        <= bus_wdata;
                    OFS_ADR_M:  cfg.adr_m        <= bus_wdata;
                    OFS_ADR_L:  cfg.adr_l        <= bus_wdata;
                    default: ;
                endcase
                if (tx_hit) tx_mem[tx_slot[TX_IW-1:0]] <= bus_wdata;
            end
            if (cap_ok) rx_mem[cap_rel[RX_IW+2:3]][cap_rel[2:0]] <= cap_bit;
        end
    end

    // Outgoing stream bit for the current serial clock
    logic [31:0] hw;
    logic [15:0] tx_rel;

    assign hw     = hdr_word(cfg);
    assign tx_rel = bit_idx - 16'd32;

    always_comb begin
        if (bit_idx < 16'd32)
            tx_bit = hw[bit_idx[4:0]];
        else if (tx_rel[15:3] < TX_LIM13)
            tx_bit = tx_mem[tx_rel[TX_IW+2:3]][tx_rel[2:0]];
        else
            tx_bit = 1'b0;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == OFS_BUSY)
            bus_rdata = {7'd0, busy};
        else if (bus_addr == OFS_STAT)
            bus_rdata = rx_mem[0];
        else if (rx_hit)
            bus_rdata = rx_mem[rx_slot[RX_IW-1:0]];
    end

    AST_CAP_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cap_stb |-> busy) else $error("capture outside cycle"); // R6
    AST_GO_KEY_ONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_GO && bus_wdata != GO_KEY && !busy) |=> !busy)
        else $error("wrong key started a cycle"); // R2

endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfe_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int TX_BYTES = 128,
    parameter int RX_BYTES = 247
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    sfe_cfg_t    cfg;
    logic        go, busy, cap_stb, tx_bit;
    logic [15:0] bit_idx;

    sfe_regs #(
        .TX_BYTES (TX_BYTES),
        .RX_BYTES (RX_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .cap_stb   (cap_stb),
        .cap_bit   (spi_miso),
        .bit_idx   (bit_idx),
        .cfg       (cfg),
        .go        (go),
        .tx_bit    (tx_bit)
    );

    sfe_seq #(
        .CLK_DIV (CLK_DIV)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .clocks  (cfg.clocks),
        .busy    (busy),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .bit_idx (bit_idx),
        .cap_stb (cap_stb)
    );

    assign spi_mosi = spi_cs_n ? 1'b0 : tx_bit;

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)) else $error("mosi moved while sck high"); // R5

endmodule

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    sflash_cmd_engine uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    // Flash model: pattern bit per serial clock, mosi log per rising edge
    function automatic bit fbit(input int k);
        return ((((k * 5) >> 1) ^ (k >> 4)) & 1) != 0;
    endfunction

    bit mosi_log [2048];
    int rise_cnt = 0;
    int fall_cnt = 0;
    int mosi_hi_moves = 0;

    always @(negedge spi_cs_n) begin
        fall_cnt = 0;
        rise_cnt = 0;
        spi_miso = fbit(0);
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        fall_cnt++;
        spi_miso = fbit(fall_cnt);
    end
    always @(posedge spi_sck) begin
        if (rise_cnt < 2048) mosi_log[rise_cnt] = spi_mosi;
        rise_cnt++;
    end
    always @(spi_mosi) if (spi_sck && !spi_cs_n) mosi_hi_moves++;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load(input logic [7:0] op, input int n,
                        input logic [7:0] ah, input logic [7:0] am, input logic [7:0] al);
        wr(11'h000, 8'(n >> 8));
        wr(11'h008, 8'(n));
        wr(11'h010, op);
        wr(11'h018, ah);
        wr(11'h020, am);
        wr(11'h028, al);
    endtask

    task automatic fire(output int c0);
        wr(11'h7F8, 8'hFF);
        c0 = cyc;
    endtask

    task automatic wait_idle(input int c0, output int dur);
        int guard = 0;
        bus_addr = 11'h001;
        #1;
        while (bus_rdata[0] && guard < 100000) begin
            @(negedge clk);
            bus_addr = 11'h001;
            #1;
            guard++;
        end
        dur = cyc - c0;
    endtask

    task automatic run(input logic [7:0] op, input int n, input logic [7:0] ah,
                       input logic [7:0] am, input logic [7:0] al, input string tag);
        int c0, dur;
        load(op, n, ah, am, al);
        fire(c0);
        wait_idle(c0, dur);
        chk(dur == 4 * n, {tag, " R3 busy cycles"}, dur, 4 * n);
        chk(rise_cnt == n, {tag, " R3 serial clocks"}, rise_cnt, n);
    endtask

    function automatic logic [7:0] exp_rx(input int h, input int j);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[b] = fbit(h + 8 * j + b);
        return v;
    endfunction

    task automatic chk_hdr(input logic [7:0] op, input logic [7:0] ah, input logic [7:0] am,
                           input logic [7:0] al, input int nb, input string tag);
        logic [31:0] w;
        int miss = 0;
        w = {al, am, ah, op};
        for (int k = 0; k < nb; k++) if (mosi_log[k] != w[k]) miss++;
        chk(miss == 0, {tag, " R4 header bits"}, miss, 0);
    endtask

    task automatic chk_rx(input int h, input int nbytes, input string tag);
        logic [7:0] d;
        int miss = 0;
        for (int j = 0; j < nbytes; j++) begin
            rd(11'(56 + 8 * j), d);
            if (d != exp_rx(h, j)) miss++;
        end
        chk(miss == 0, {tag, " R6 captured bytes"}, miss, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int c0, dur, miss;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(11'h001, d);
        chk(d == 8'h00, "R1 busy after reset", d, 0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins idle", {spi_cs_n, spi_sck}, 2);
        rd(11'h020, d);
        chk(d == 8'h00, "R1 status zero", d, 0);
        miss = 0;
        for (int j = 0; j < 247; j += 13) begin
            rd(11'(56 + 8 * j), d);
            if (d != 8'h00) miss++;
        end
        chk(miss == 0, "R1 capture window zero", miss, 0);

        // write enable, 8 clocks
        run(8'h60, 8, 8'h00, 8'h00, 8'h00, "wren");
        chk_hdr(8'h60, 8'h00, 8'h00, 8'h00, 8, "wren");

        // status, 16 clocks, header 8
        run(8'hA0, 16, 8'h5A, 8'h33, 8'hC3, "stat");
        chk_hdr(8'hA0, 8'h5A, 8'h33, 8'hC3, 16, "stat");
        rd(11'h020, d);
        chk(d == exp_rx(8, 0), "R7 status at 0x20", d, exp_rx(8, 0));
        chk_rx(8, 1, "stat");

        // id, 40 clocks, header 8
        run(8'hD5, 40, 8'h81, 8'h42, 8'h24, "id");
        chk_hdr(8'hD5, 8'h81, 8'h42, 8'h24, 32, "id");
        chk_rx(8, 4, "id");

        // read data, 3 bytes, header 32
        run(8'hC0, 56, 8'h10, 8'h20, 8'h30, "read");
        chk_hdr(8'hC0, 8'h10, 8'h20, 8'h30, 32, "read");
        chk_rx(32, 3, "read");

        // page write with 4 data bytes
        for (int k = 0; k < 4; k++) wr(11'(48 + 8 * k), 8'(k * 37 + 5));
        run(8'h40, 64, 8'h01, 8'h02, 8'h04, "prog");
        miss = 0;
        for (int k = 0; k < 32; k++) begin
            logic [7:0] v;
            v = 8'((k / 8) * 37 + 5);
            if (mosi_log[32 + k] != v[k % 8]) miss++;
        end
        chk(miss == 0, "R4 write data bits", miss, 0);
        chk_rx(32, 4, "prog");
        chk(mosi_hi_moves == 0, "R5 mosi stable while sck high", mosi_hi_moves, 0);

        // R2 wrong key and zero count start nothing
        wr(11'h7F8, 8'h7F);
        repeat (3) @(negedge clk);
        rd(11'h001, d);
        chk(d == 8'h00 && spi_cs_n, "R2 wrong key ignored", d, 0);
        load(8'h60, 0, 8'h00, 8'h00, 8'h00);
        wr(11'h7F8, 8'hFF);
        repeat (3) @(negedge clk);
        rd(11'h001, d);
        chk(d == 8'h00 && spi_cs_n, "R2 zero count ignored", d, 0);

        // R8 restart and count rewrite while busy
        load(8'h60, 24, 8'h00, 8'h00, 8'h00);
        fire(c0);
        repeat (6) @(negedge clk);
        wr(11'h008, 8'd100);
        wr(11'h7F8, 8'hFF);
        wait_idle(c0, dur);
        chk(dur == 96, "R8 busy length unchanged", dur, 96);
        chk(rise_cnt == 24, "R8 clock count unchanged", rise_cnt, 24);
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R8 no second cycle", spi_cs_n, 1);

        // R9 write window end: bytes 128 and 129 send zero
        for (int k = 0; k < 130; k++) wr(11'(48 + 8 * k), 8'(k * 11 + 1));
        run(8'h40, 32 + 8 * 130, 8'h00, 8'h00, 8'h00, "txend");
        miss = 0;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = 8'(127 * 11 + 1);
            if (mosi_log[32 + 127 * 8 + k] != v[k]) miss++;
        end
        chk(miss == 0, "R9 last write byte sent", miss, 0);
        miss = 0;
        for (int k = 0; k < 16; k++) if (mosi_log[32 + 128 * 8 + k] != 1'b0) miss++;
        chk(miss == 0, "R9 bytes past window send zero", miss, 0);

        // R9 capture window end
        run(8'hC0, 32 + 8 * 249, 8'h00, 8'h00, 8'h00, "rxend");
        rd(11'h7E8, d);
        chk(d == exp_rx(32, 246), "R9 last capture byte", d, exp_rx(32, 246));
        rd(11'h038, d);
        chk(d == exp_rx(32, 0), "R6 first capture byte", d, exp_rx(32, 0));
        rd(11'h7F0, d);
        chk(d == 8'h00, "R9 read past window", d, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule